// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a 32-bit asynchronous NOR flash bus. The bus is made of four byte-wide devices. They share one address bus and one write strobe, and each has its own chip select. A client hands over one request at a time on a valid/ready pair: a single-word read, a word program, an erase of any set of sectors, or a whole-chip erase. The controller turns the request into the required series of write cycles. Each command byte is copied onto all four byte lanes, so the four devices act in step. All strobe widths are counted in system clocks.

After the last write cycle, the controller reads the affected word over and over. While a device is still busy with its embedded operation, it returns bit 7 of its byte inverted. The controller finishes only when bit 7 of every lane shows the final value. It reports an error instead if a programmable cycle budget runs out first. A plain read asserts the output enable for a fixed access window and returns the sampled word.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held, the outputs are idle: write strobe high, output enable high, all chip selects high, data drive disabled, `req_ready` high and `rsp_valid` low.
- R2: `req_op` encodes 0 = read, 1 = program, 2 = sector erase, 3 = chip erase. A program (op 1) issues exactly four write cycles in this order: AAH at 5555H, 55H at 2AAAH, A0H at 5555H, then `req_data` at `req_addr`. Each command byte is replicated on all four lanes, and all four chip selects are low during every write.
- R3: An erase issues the five-cycle prefix AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH. For a chip erase (op 3) a single sixth cycle follows: 10H@5555H.
- R4: For a sector erase (op 2), the prefix is followed by one 30H cycle per set bit of `req_sectors`, in ascending bit order. Each of these cycles has the sector index in address bits 18..16 and zeros in bits 15..0.
- R5: A sector erase with an empty `req_sectors` mask produces no write strobe and answers with `rsp_err` = 1.
- R6: The write strobe stays low for exactly T_WP clocks and stays high for at least T_WPH clocks between pulses. Address and data are stable while it is low. Write strobe and output enable are never low together.
- R7: Completion polling ends only when bit 7 of every lane equals the expected bit. For a program, that is bit 7 of the same lane of the programmed data. For an erase, it is 1. On success, `rsp_err` = 0 and `rsp_data` carries the final word read.
- R8: If polling has run for `poll_limit` clocks without a match, the operation ends with `rsp_err` = 1.
- R9: A read (op 0) produces no write strobe. It holds the output enable low for exactly T_ACC clocks and returns the word present at the end of that window.
- R10: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low until the response. `rsp_valid` is a one-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, will take a request |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | 19 | Word address for read or program |
| req_data | input | 32 | Word to program |
| req_sectors | input | 8 | Sector set for sector erase, bit n = sector n |
| poll_limit | input | 32 | Polling budget in clocks |
| rsp_valid | output | 1 | One-clock response strobe |
| rsp_err | output | 1 | Timeout or empty sector set |
| rsp_data | output | 32 | Read word or last polled word |
| fl_addr | output | 19 | Flash address bus |
| fl_dout | output | 32 | Data driven toward the flash |
| fl_dout_en | output | 1 | Drive enable for `fl_dout` |
| fl_din | input | 32 | Data returned by the flash |
| fl_cs_n | output | 4 | Chip selects, one per byte lane |
| fl_we_n | output | 1 | Shared write strobe |
| fl_oe_n | output | 1 | Shared output enable |

## Verification
The bound checker watches the following on every clock:
- the low width of the write strobe;
- that address and data stay stable while the strobe is low;
- that the strobe and the output enable never overlap;
- that the chip selects always move together;
- that the data drive is off whenever the output enable is low;
- the response handshake.

Other behaviour is shown only by the bench's scenarios, run against a behavioural model of the four devices:
- the order and contents of the command cycles;
- the ascending sector order;
- that polling waits for the slowest lane;
- the timeout budget;
- the empty-mask error.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W  = 19,
  parameter int LANES   = 4,
  parameter int SECTORS = 8,
  parameter int T_WP    = 10,
  parameter int T_WPH   = 5,
  parameter int T_ACC   = 15,
  parameter int LIM_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [8*LANES-1:0]   req_data,
  input  logic [SECTORS-1:0]   req_sectors,
  input  logic [LIM_W-1:0]     poll_limit,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [8*LANES-1:0]   rsp_data,
  output logic [ADDR_W-1:0]    fl_addr,
  output logic [8*LANES-1:0]   fl_dout,
  output logic                 fl_dout_en,
  input  logic [8*LANES-1:0]   fl_din,
  output logic [LANES-1:0]     fl_cs_n,
  output logic                 fl_we_n,
  output logic                 fl_oe_n
);
  localparam int DW    = 8 * LANES;
  localparam int SEC_W = $clog2(SECTORS);
  localparam int TM1   = (T_WP > T_WPH) ? T_WP : T_WPH;
  localparam int TMAX  = (TM1 > T_ACC) ? TM1 : T_ACC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(32'h5555);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(32'h2AAA);
  localparam logic [DW-1:0] MSB_MASK = {LANES{8'h80}};
  localparam logic [1:0] OP_RD = 2'd0, OP_PG = 2'd1, OP_SE = 2'd2, OP_CE = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WLO, S_WHI, S_RD, S_GAP, S_RSP} st_t;

  st_t                st;
  logic [1:0]         op;
  logic [2:0]         step;
  logic [ADDR_W-1:0]  tgt, addr_q;
  logic [DW-1:0]      wdata, dout_q, rdata;
  logic [SECTORS-1:0] smask;
  logic [TW-1:0]      tmr;
  logic [LIM_W-1:0]   pcnt;
  logic               polling, err;

  logic [SEC_W-1:0]   low_idx;
  logic               found;
  logic [ADDR_W-1:0]  step_addr;
  logic [DW-1:0]      step_data;
  logic               last_wr, more_sect, lanes_done;

  always_comb begin
    low_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < SECTORS; i++)
      if (!found && smask[i]) begin
        low_idx = SEC_W'(i);
        found   = 1'b1;
      end
  end

  assign more_sect = |(smask & (smask - 1'b1));

  always_comb begin
    step_addr = A_HI;
    step_data = {LANES{8'hAA}};
    case (step)
      3'd0: ;
      3'd1: begin step_addr = A_LO; step_data = {LANES{8'h55}}; end
      3'd2: step_data = (op == OP_PG) ? {LANES{8'hA0}} : {LANES{8'h80}};
      3'd3: if (op == OP_PG) begin step_addr = tgt; step_data = wdata; end
      3'd4: begin step_addr = A_LO; step_data = {LANES{8'h55}}; end
      default:
        if (op == OP_CE) step_data = {LANES{8'h10}};
        else begin
          step_addr = {low_idx, {(ADDR_W-SEC_W){1'b0}}};
          step_data = {LANES{8'h30}};
        end
    endcase
  end

  assign last_wr    = (op == OP_PG) ? (step == 3'd3)
                                    : (step == 3'd5 && (op == OP_CE || !more_sect));
  assign lanes_done = (((fl_din ^ ((op == OP_PG) ? wdata : '1)) & MSB_MASK) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_RD; step <= '0; tgt <= '0; addr_q <= '0;
      wdata <= '0; dout_q <= '0; rdata <= '0; smask <= '0; tmr <= '0;
      pcnt <= '0; polling <= 1'b0; err <= 1'b0;
      fl_dout_en <= 1'b0; fl_cs_n <= '1; fl_we_n <= 1'b1; fl_oe_n <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op <= req_op; tgt <= req_addr; wdata <= req_data; smask <= req_sectors;
          step <= '0; err <= 1'b0; polling <= 1'b0; tmr <= '0;
          if (req_op == OP_RD) begin
            addr_q <= req_addr; fl_cs_n <= '0; fl_oe_n <= 1'b0; st <= S_RD;
          end else if (req_op == OP_SE && req_sectors == '0) begin
            err <= 1'b1; st <= S_RSP;
          end else st <= S_WSET;
        end
        S_WSET: begin
          addr_q <= step_addr; dout_q <= step_data; fl_dout_en <= 1'b1;
          fl_cs_n <= '0; fl_we_n <= 1'b0; tmr <= '0; st <= S_WLO;
        end
        S_WLO:
          if (tmr == TW'(T_WP - 1)) begin
            fl_we_n <= 1'b1; tmr <= '0; st <= S_WHI;
          end else tmr <= tmr + 1'b1;
        S_WHI:
          if (tmr == TW'(T_WPH - 1)) begin
            tmr <= '0;
            if (last_wr) begin
              fl_dout_en <= 1'b0; fl_oe_n <= 1'b0; polling <= 1'b1;
              pcnt <= '0; st <= S_RD;
            end else begin
              if (step == 3'd5) smask <= smask & (smask - 1'b1);
              else step <= step + 1'b1;
              st <= S_WSET;
            end
          end else tmr <= tmr + 1'b1;
        S_RD: begin
          if (polling) pcnt <= pcnt + 1'b1;
          if (tmr == TW'(T_ACC - 1)) begin
            tmr <= '0; fl_oe_n <= 1'b1; rdata <= fl_din;
            if (!polling || lanes_done) begin
              fl_cs_n <= '1; st <= S_RSP;
            end else if (pcnt >= poll_limit) begin
              err <= 1'b1; fl_cs_n <= '1; st <= S_RSP;
            end else st <= S_GAP;
          end else tmr <= tmr + 1'b1;
        end
        S_GAP: begin
          pcnt <= pcnt + 1'b1; fl_oe_n <= 1'b0; st <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RSP);
  assign rsp_err   = err;
  assign rsp_data  = rdata;
  assign fl_addr   = addr_q;
  assign fl_dout   = dout_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int LANES  = 4,
  parameter int T_WP   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [ADDR_W-1:0]  fl_addr,
  input logic [8*LANES-1:0] fl_dout,
  input logic               fl_dout_en,
  input logic [LANES-1:0]   fl_cs_n,
  input logic               fl_we_n,
  input logic               fl_oe_n
);
  localparam int CW = $clog2(T_WP + 2) + 1;
  logic [CW-1:0] wlo_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wlo_cnt <= '0;
    else if (!fl_we_n) wlo_cnt <= wlo_cnt + 1'b1;
    else wlo_cnt <= '0;

  assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> wlo_cnt == CW'(T_WP));
  assert_we_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_oe_n);
  assert_cs_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cs_n == '0) || (fl_cs_n == '1));
  assert_we_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (fl_cs_n == '0 && fl_dout_en));
  assert_bus_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dout_en);
  assert_rsp_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .T_WP(T_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en),
  .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int T_WP = 10, T_WPH = 5, T_ACC = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [18:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [7:0] req_sectors = '0;
  logic [31:0] poll_limit = 32'd10000;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic [18:0] fl_addr;
  logic [31:0] fl_dout, fl_din;
  logic fl_dout_en, fl_we_n, fl_oe_n;
  logic [3:0] fl_cs_n;

  always #2 clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_sectors(req_sectors),
    .poll_limit(poll_limit), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_din(fl_din),
    .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [18:0] a);
    return 32'h5A3C_0000 ^ {13'h0, a};
  endfunction

  // behavioural model of four byte-wide devices
  int cyc = 0;
  logic we_d = 1'b1, armed = 1'b0, have = 1'b0;
  logic [31:0] word = '0;
  logic [18:0] waddr = '0;
  int lbusy [4] = '{0, 0, 0, 0};
  int busy_len = 20, skew = 5;
  int wcnt = 0;
  logic [18:0] log_a [0:127];
  logic [31:0] log_d [0:127];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    we_d <= fl_we_n;
    for (int i = 0; i < 4; i++) if (lbusy[i] > 0) lbusy[i] <= lbusy[i] - 1;
    if (we_d == 1'b0 && fl_we_n == 1'b1) begin
      log_a[wcnt % 128] <= fl_addr;
      log_d[wcnt % 128] <= fl_dout;
      wcnt <= wcnt + 1;
      if (armed) begin
        word <= fl_dout; waddr <= fl_addr; have <= 1'b1; armed <= 1'b0;
        for (int i = 0; i < 4; i++) lbusy[i] <= busy_len + i * skew;
      end else if (fl_dout == 32'hA0A0A0A0) armed <= 1'b1;
      else if (fl_dout == 32'h10101010 || fl_dout == 32'h30303030) begin
        word <= '1; waddr <= fl_addr; have <= 1'b1;
        for (int i = 0; i < 4; i++) lbusy[i] <= busy_len + i * skew;
      end
    end
  end

  always_comb begin
    logic [31:0] t;
    t = (have && fl_addr == waddr) ? word : pat(fl_addr);
    for (int i = 0; i < 4; i++) begin
      fl_din[8*i +: 8] = t[8*i +: 8];
      if (lbusy[i] > 0) fl_din[8*i +: 8] = {~t[8*i+7], t[8*i +: 7] ^ 7'h15};
    end
  end

  // strobe monitor, sampled on the falling clock edge (R6, R9)
  logic pwe = 1'b1, poe = 1'b1, seen_pulse = 1'b0;
  int lo_len = 0, hi_len = 0, oe_len = 0, last_oe_len = 0, last_rise = 0;
  always @(negedge clk) if (rst_n) begin
    if (!fl_we_n) lo_len++;
    else if (fl_cs_n == '0) hi_len++;
    if (pwe && !fl_we_n && seen_pulse)
      chk(hi_len - 1 >= T_WPH, "R6", "strobe high gap", 64'(hi_len - 1), 64'(T_WPH));
    if (!pwe && fl_we_n) begin
      chk(lo_len == T_WP, "R6", "strobe low width", 64'(lo_len), 64'(T_WP));
      lo_len = 0; hi_len = 1; seen_pulse = 1'b1; last_rise = cyc;
    end
    if (fl_cs_n != '0) begin seen_pulse = 1'b0; hi_len = 0; end
    if (!fl_oe_n) oe_len++;
    else if (!poe) begin last_oe_len = oe_len; oe_len = 0; end
    pwe = fl_we_n; poe = fl_oe_n;
  end

  logic [18:0] exp_a [0:15];
  logic [31:0] exp_d [0:15];
  task automatic build(input logic [1:0] op, input logic [18:0] a, input logic [31:0] d,
                       input logic [7:0] m, output int n);
    n = 0;
    if (op == 2'd0 || (op == 2'd2 && m == 0)) return;
    exp_a[0] = 19'h5555; exp_d[0] = 32'hAAAAAAAA;
    exp_a[1] = 19'h2AAA; exp_d[1] = 32'h55555555;
    if (op == 2'd1) begin
      exp_a[2] = 19'h5555; exp_d[2] = 32'hA0A0A0A0;
      exp_a[3] = a; exp_d[3] = d; n = 4; return;
    end
    exp_a[2] = 19'h5555; exp_d[2] = 32'h80808080;
    exp_a[3] = 19'h5555; exp_d[3] = 32'hAAAAAAAA;
    exp_a[4] = 19'h2AAA; exp_d[4] = 32'h55555555;
    n = 5;
    if (op == 2'd3) begin exp_a[5] = 19'h5555; exp_d[5] = 32'h10101010; n = 6; end
    else for (int i = 0; i < 8; i++) if (m[i]) begin
      exp_a[n] = {3'(i), 16'h0}; exp_d[n] = 32'h30303030; n++;
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [18:0] a, input logic [31:0] d,
                        input logic [7:0] m, input logic [31:0] lim,
                        output logic e, output logic [31:0] q, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_sectors = m; poll_limit = lim;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready after accept", 64'(req_ready), 64'd0);
    while (!rsp_valid) @(negedge clk);
    e = rsp_err; q = rsp_data; lat = cyc - last_rise;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10", "one-cycle response", 64'({rsp_valid, req_ready}), 64'b01);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [18:0] addr;
    logic [31:0] data;
    logic [7:0]  mask;
    logic        err;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd1, 19'h12345, 32'hCAFE0180, 8'h00, 1'b0},
    '{2'd3, 19'h00000, 32'h00000000, 8'h00, 1'b0},
    '{2'd2, 19'h00000, 32'h00000000, 8'h01, 1'b0},
    '{2'd2, 19'h00000, 32'h00000000, 8'hA4, 1'b0},
    '{2'd1, 19'h0BEEF, 32'h00000000, 8'h00, 1'b0},
    '{2'd2, 19'h00000, 32'h00000000, 8'h00, 1'b1},
    '{2'd0, 19'h7ABCD, 32'h00000000, 8'h00, 1'b0}
  };

  bit done = 1'b0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [31:0] q;
    int lat, n, base;
    string tag;
    repeat (3) @(negedge clk);
    // R1: idle outputs while reset is held
    chk(fl_we_n && fl_oe_n && fl_cs_n == 4'hF && !fl_dout_en, "R1", "bus idle in reset",
        64'({fl_we_n, fl_oe_n, fl_cs_n, fl_dout_en}), 64'b1111110);
    chk(req_ready && !rsp_valid, "R1", "handshake in reset", 64'({req_ready, rsp_valid}), 64'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[v]) begin
      base = wcnt;
      build(VECS[v].op, VECS[v].addr, VECS[v].data, VECS[v].mask, n);
      tag = (VECS[v].op == 2'd1) ? "R2" : (VECS[v].op == 2'd3) ? "R3" :
            (VECS[v].op == 2'd0) ? "R9" : (VECS[v].mask == 0) ? "R5" : "R4";
      do_req(VECS[v].op, VECS[v].addr, VECS[v].data, VECS[v].mask, 32'd10000, e, q, lat);
      chk(wcnt - base == n, tag, "write count", 64'(wcnt - base), 64'(n));
      for (int k = 0; k < n && k < wcnt - base; k++) begin
        chk(log_a[(base + k) % 128] == exp_a[k], tag, $sformatf("write %0d addr", k),
            64'(log_a[(base + k) % 128]), 64'(exp_a[k]));
        chk(log_d[(base + k) % 128] == exp_d[k], tag, $sformatf("write %0d data", k),
            64'(log_d[(base + k) % 128]), 64'(exp_d[k]));
      end
      chk(e == VECS[v].err, tag, "error flag", 64'(e), 64'(VECS[v].err));
      if (!VECS[v].err) begin
        logic [31:0] ex;
        ex = (VECS[v].op == 2'd0) ? pat(VECS[v].addr) :
             (VECS[v].op == 2'd1) ? VECS[v].data : 32'hFFFFFFFF;
        chk(q == ex, (VECS[v].op == 2'd0) ? "R9" : "R7", "response word", 64'(q), 64'(ex));
      end
      if (VECS[v].op == 2'd0)
        chk(last_oe_len == T_ACC, "R9", "output enable window", 64'(last_oe_len), 64'(T_ACC));
    end

    // R7: the slowest lane decides completion
    busy_len = 30; skew = 20;
    do_req(2'd1, 19'h01234, 32'h80808080, 8'h00, 32'd10000, e, q, lat);
    chk(!e && q == 32'h80808080, "R7", "skewed lanes result", 64'({e, q}), 64'h80808080);
    chk(lat >= 90 && lat <= 90 + 2 * (T_ACC + 1) + 6, "R7", "waits for last lane", 64'(lat), 64'd90);

    // R8: polling budget expires while the devices stay busy
    busy_len = 2000; skew = 0;
    do_req(2'd3, 19'h0, 32'h0, 8'h00, 32'd50, e, q, lat);
    chk(e == 1'b1, "R8", "timeout error", 64'(e), 64'd1);
    chk(lat >= 50 && lat <= 50 + T_WPH + T_ACC + 4, "R8", "timeout latency", 64'(lat), 64'd50);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule